// File: doc/BRIEF.md
# DDR2 Extended Mode Register Sequencer

This block sits on the controller side of a DDR2 SDRAM interface. It programs the two refresh-related extended mode registers and decides when reads may start after the DLL has been enabled or reset. A client raises a request that names the target register and, for the second extended register, a flag that turns on the faster self-refresh rate used at high temperature. The request is accepted only while every bank is precharged and CKE is high. The block then drives a mode register write on the command pins for exactly one cycle. It waits out the mode register cycle time, reports completion, and latches an initialization flag once the second extended register has been written.

Alongside the command path, a lock guard follows the DLL. An enable or reset of the DLL starts a relock wait. Self-refresh entry turns the DLL off, and self-refresh exit turns it back on, which starts a fresh wait. The read-allowed flag stays low until the full wait has elapsed.

Top module: `ddr2_xmr_seq`

## Requirements
- R1: After reset the command pins carry a no-operation (chip select low, row strobe, column strobe and write enable high, bank and row address zero), and busy, done, init_done and read_ok are all low.
- R2: A request sampled on a clock edge while the issue conditions hold puts a mode register write (all four command pins low) on the pins in the following cycle, for that one cycle only. Every other cycle carries the no-operation.
- R3: A request with select 0 targets the second extended register: bank address 2'b10, row address bit 7 equal to the high-temperature flag, all other row bits 0.
- R4: A request with select 1 targets the third extended register: bank address 2'b11 and every row bit 0. The high-temperature flag is ignored.
- R5: While all_banks_idle or cke_high is low, a request is not issued and busy stays low. The request stays pending and is issued in the cycle after the edge at which both conditions hold.
- R6: busy is high from the command cycle until done. done is a one-cycle pulse exactly T_MRD cycles after the command cycle, and busy is low in that cycle.
- R7: A request held high while busy is not dropped. It is issued in the cycle after the done pulse.
- R8: init_done rises in the done cycle of the first write to the second extended register and then stays high. Writes to the third extended register do not set it.
- R9: read_ok is low until the DLL is enabled. After a dll_reset pulse it is low, and it rises exactly LOCK_CYCLES cycles after the edge that sampled the pulse.
- R10: A further dll_reset pulse during the wait restarts it from the new pulse.
- R11: An sr_enter pulse makes read_ok low in the next cycle. A dll_reset pulse during self-refresh is ignored. An sr_exit pulse restarts the wait, so read_ok rises LOCK_CYCLES cycles after the edge that sampled the exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Level request to write an extended register, held until issued |
| req_sel | input | 1 | 0 selects the second extended register, 1 the third |
| req_hts | input | 1 | High-temperature self-refresh rate enable for the second register |
| all_banks_idle | input | 1 | All banks are precharged |
| cke_high | input | 1 | CKE is already high |
| dll_reset | input | 1 | One-cycle pulse: the DLL was enabled or reset |
| sr_enter | input | 1 | One-cycle pulse: self-refresh entered |
| sr_exit | input | 1 | One-cycle pulse: self-refresh exited |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank address |
| cmd_addr | output | ROW_W | Row address |
| busy | output | 1 | A write is on the bus or in its cycle-time window |
| done | output | 1 | One-cycle completion pulse |
| init_done | output | 1 | The second extended register has been written at least once |
| read_ok | output | 1 | A read command may be issued |

## Verification
The mode register write appears one cycle after the edge that sampled an accepted request. done follows T_MRD cycles after that. read_ok rises LOCK_CYCLES cycles after the edge that sampled a DLL enable or self-refresh exit. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the one just after the stimulus edge and samples each output on the exact cycle it is due. It also checks the cycle before each deadline, which catches a result that arrives one cycle early.

// File: rtl/ddr2_xmr_pkg.sv
// Package: shared command encodings and state types for the extended
// mode register sequencer. Assumes the usual DDR2 active-low command pins.
package ddr2_xmr_pkg;

    // Command pin bundle in the order chip select, row, column, write
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t CMD_NOP = 4'b0111;
    localparam cmd_pins_t CMD_MRS = 4'b0000;

    // Row address bit that carries the high-temperature refresh rate flag
    localparam int HTS_BIT = 7;

    typedef enum logic {
        XMR_TWO   = 1'b0,
        XMR_THREE = 1'b1
    } xmr_sel_e;

    typedef enum logic {
        ISS_IDLE = 1'b0,
        ISS_WAIT = 1'b1
    } iss_state_e;

    typedef enum logic [1:0] {
        DLL_OFF     = 2'd0,
        DLL_LOCKING = 2'd1,
        DLL_LOCKED  = 2'd2
    } dll_state_e;

endpackage

// File: rtl/xmr_cmd_enc.sv
// Module: xmr_cmd_enc
// Builds the bank and row address of an extended register write from the
// request fields. Purely combinational. Assumes ROW_W > HTS_BIT.
module xmr_cmd_enc
    import ddr2_xmr_pkg::*;
#(
    parameter int ROW_W = 13
) (
    input  logic             sel,
    input  logic             hts,
    output logic [1:0]       ba,
    output logic [ROW_W-1:0] addr
);

    // Bank select is 1x with x the register choice; only register two carries a flag
    always_comb begin
        ba   = {1'b1, sel};
        addr = '0;
        if (xmr_sel_e'(sel) == XMR_TWO) begin
            addr[HTS_BIT] = hts;
        end
    end

endmodule

// File: rtl/xmr_issue.sv
// Module: xmr_issue
// Accepts an extended register request when the device is idle and
// powered up, drives one mode register write cycle, waits T_MRD cycles and
// pulses done. Assumes req_valid is held until the command appears.
module xmr_issue
    import ddr2_xmr_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int T_MRD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_sel,
    input  logic             all_banks_idle,
    input  logic             cke_high,
    input  logic [1:0]       enc_ba,
    input  logic [ROW_W-1:0] enc_addr,
    output cmd_pins_t        pins,
    output logic [1:0]       ba,
    output logic [ROW_W-1:0] addr,
    output logic             busy,
    output logic             done,
    output logic             init_done
);

    localparam int MRD_W = (T_MRD > 1) ? $clog2(T_MRD) : 1;
    localparam int GAP_W = $clog2(T_MRD + 2);

    iss_state_e       state;
    logic [MRD_W-1:0] wait_cnt;
    xmr_sel_e         last_sel;
    logic             accept;
    logic             finish;

    assign accept = (state == ISS_IDLE) && req_valid && all_banks_idle && cke_high;
    assign finish = (state == ISS_WAIT) && (wait_cnt == MRD_W'(T_MRD - 1));
    assign busy   = (state == ISS_WAIT);

    // Issue state and cycle-time counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ISS_IDLE;
            wait_cnt <= '0;
            last_sel <= XMR_TWO;
        end else if (accept) begin
            state    <= ISS_WAIT;
            wait_cnt <= '0;
            last_sel <= xmr_sel_e'(req_sel);
        end else if (finish) begin
            state    <= ISS_IDLE;
        end else if (state == ISS_WAIT) begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end

    // Registered command pins: one write cycle on accept, otherwise no-op
    always_ff @(posedge clk) begin
        if (!rst_n || !accept) begin
            pins <= CMD_NOP;
            ba   <= '0;
            addr <= '0;
        end else begin
            pins <= CMD_MRS;
            ba   <= enc_ba;
            addr <= enc_addr;
        end
    end

    // Completion pulse and sticky initialization flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            init_done <= 1'b0;
        end else begin
            done      <= finish;
            init_done <= init_done || (finish && last_sel == XMR_TWO);
        end
    end

    // Checker-only count of cycles since the last write cycle, saturating
    logic [GAP_W-1:0] gap_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= GAP_W'(T_MRD + 1);
        end else if (pins == CMD_MRS) begin
            gap_cnt <= GAP_W'(1);
        end else if (gap_cnt != GAP_W'(T_MRD + 1)) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    AST_MRS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == CMD_MRS) |=> (pins == CMD_NOP)); // R2
    AST_MRS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == CMD_MRS) |-> $past(all_banks_idle && cke_high)); // R5
    AST_REG3_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == CMD_MRS && ba == 2'b11) |-> (addr == '0)); // R4
    AST_REG2_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == CMD_MRS && ba == 2'b10) |-> ((addr & ~(ROW_W'(1) << HTS_BIT)) == '0)); // R3
    AST_DONE_AFTER_MRD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (gap_cnt == GAP_W'(T_MRD) && !busy)); // R6
    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R8

endmodule

// File: rtl/xmr_dll_guard.sv
// Module: xmr_dll_guard
// Tracks the DLL through enable, reset and self-refresh and holds read_ok
// low until LOCK_CYCLES cycles have passed since the DLL came back on.
// Assumes sr_enter, sr_exit and dll_reset are single-cycle pulses.
module xmr_dll_guard
    import ddr2_xmr_pkg::*;
#(
    parameter int LOCK_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dll_reset,
    input  logic sr_enter,
    input  logic sr_exit,
    output logic read_ok
);

    localparam int LCK_W = $clog2(LOCK_CYCLES + 2);

    dll_state_e       state;
    logic             in_sr;
    logic [LCK_W-1:0] lock_cnt;
    logic             restart;

    assign restart = sr_exit || (dll_reset && !in_sr);
    assign read_ok = (state == DLL_LOCKED);

    // Self-refresh residency flag
    always_ff @(posedge clk) begin
        if (!rst_n)        in_sr <= 1'b0;
        else if (sr_enter) in_sr <= 1'b1;
        else if (sr_exit)  in_sr <= 1'b0;
    end

    // Lock state and relock counter; entry to self-refresh has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= DLL_OFF;
            lock_cnt <= '0;
        end else if (sr_enter) begin
            state    <= DLL_OFF;
        end else if (restart) begin
            state    <= DLL_LOCKING;
            lock_cnt <= '0;
        end else if (state == DLL_LOCKING) begin
            if (lock_cnt == LCK_W'(LOCK_CYCLES - 1)) state <= DLL_LOCKED;
            else                                     lock_cnt <= lock_cnt + 1'b1;
        end
    end

    // Checker-only count of cycles since the last DLL on event at the ports
    logic [LCK_W-1:0] since_on;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_on <= '0;
        end else if (sr_exit || dll_reset) begin
            since_on <= '0;
        end else if (since_on != LCK_W'(LOCK_CYCLES + 1)) begin
            since_on <= since_on + 1'b1;
        end
    end

    AST_SR_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sr_enter |=> !read_ok); // R11
    AST_LOCK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(read_ok) |-> (since_on == LCK_W'(LOCK_CYCLES))); // R9

endmodule

// File: rtl/ddr2_xmr_seq.sv
// Module: ddr2_xmr_seq
// Top of the extended mode register sequencer: request encoder, command
// issue with cycle-time wait, and DLL relock guard for reads.
// Assumes one client and a single rank.
module ddr2_xmr_seq
    import ddr2_xmr_pkg::*;
#(
    parameter int ROW_W       = 13,
    parameter int T_MRD       = 2,
    parameter int LOCK_CYCLES = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_sel,
    input  logic             req_hts,
    input  logic             all_banks_idle,
    input  logic             cke_high,
    input  logic             dll_reset,
    input  logic             sr_enter,
    input  logic             sr_exit,
    output logic             cmd_cs_n,
    output logic             cmd_ras_n,
    output logic             cmd_cas_n,
    output logic             cmd_we_n,
    output logic [1:0]       cmd_ba,
    output logic [ROW_W-1:0] cmd_addr,
    output logic             busy,
    output logic             done,
    output logic             init_done,
    output logic             read_ok
);

    logic [1:0]       enc_ba;
    logic [ROW_W-1:0] enc_addr;
    cmd_pins_t        pins;

    xmr_cmd_enc #(.ROW_W(ROW_W)) u_enc (
        .sel  (req_sel),
        .hts  (req_hts),
        .ba   (enc_ba),
        .addr (enc_addr)
    );

    xmr_issue #(.ROW_W(ROW_W), .T_MRD(T_MRD)) u_issue (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_sel        (req_sel),
        .all_banks_idle (all_banks_idle),
        .cke_high       (cke_high),
        .enc_ba         (enc_ba),
        .enc_addr       (enc_addr),
        .pins           (pins),
        .ba             (cmd_ba),
        .addr           (cmd_addr),
        .busy           (busy),
        .done           (done),
        .init_done      (init_done)
    );

    xmr_dll_guard #(.LOCK_CYCLES(LOCK_CYCLES)) u_dll (
        .clk       (clk),
        .rst_n     (rst_n),
        .dll_reset (dll_reset),
        .sr_enter  (sr_enter),
        .sr_exit   (sr_exit),
        .read_ok   (read_ok)
    );

    assign cmd_cs_n  = pins.cs_n;
    assign cmd_ras_n = pins.ras_n;
    assign cmd_cas_n = pins.cas_n;
    assign cmd_we_n  = pins.we_n;

endmodule

// File: tb/ddr2_xmr_seq_tb.sv
// Directed bench for ddr2_xmr_seq: one task per scenario, falling-edge I/O.
module ddr2_xmr_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ROW_W      = 13;
    localparam int T_MRD      = 2;
    localparam int LOCK       = 200;

    logic clk = 1'b0;
    logic rst_n, req_valid, req_sel, req_hts, all_banks_idle, cke_high;
    logic dll_reset, sr_enter, sr_exit;
    logic cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
    logic [1:0] cmd_ba;
    logic [ROW_W-1:0] cmd_addr;
    logic busy, done, init_done, read_ok;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr2_xmr_seq #(.ROW_W(ROW_W), .T_MRD(T_MRD), .LOCK_CYCLES(LOCK)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
        .req_hts(req_hts), .all_banks_idle(all_banks_idle), .cke_high(cke_high),
        .dll_reset(dll_reset), .sr_enter(sr_enter), .sr_exit(sr_exit),
        .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
        .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr),
        .busy(busy), .done(done), .init_done(init_done), .read_ok(read_ok)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] pins();
        return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
    endfunction

    // Write with request at one falling edge; checks command, busy and done timing
    task automatic do_write(input logic sel, input logic hts,
                            input logic [1:0] exp_ba, input logic [ROW_W-1:0] exp_addr,
                            input string tag);
        req_valid = 1'b1; req_sel = sel; req_hts = hts;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R2 write pins"}, 32'(pins()), 32'h0);
        chk({tag, " bank"}, 32'(cmd_ba), 32'(exp_ba));
        chk({tag, " row"}, 32'(cmd_addr), 32'(exp_addr));
        chk({tag, " R6 busy in cmd"}, 32'(busy), 32'h1);
        for (int k = 1; k < T_MRD; k++) begin
            @(negedge clk);
            chk({tag, " R2 nop after"}, 32'(pins()), 32'h7);
            chk({tag, " R6 no early done"}, 32'(done), 32'h0);
        end
        @(negedge clk);
        chk({tag, " R6 done"}, 32'(done), 32'h1);
        chk({tag, " R6 busy low"}, 32'(busy), 32'h0);
        @(negedge clk);
        chk({tag, " R6 done pulse"}, 32'(done), 32'h0);
    endtask

    task automatic t_reset();
        chk("R1 pins", 32'(pins()), 32'h7);
        chk("R1 bank/row", 32'({cmd_ba, cmd_addr}), 32'h0);
        chk("R1 flags", 32'({busy, done, init_done, read_ok}), 32'h0);
    endtask

    task automatic t_reg3();
        do_write(1'b1, 1'b1, 2'b11, '0, "R4 reg3");
        chk("R8 reg3 no init", 32'(init_done), 32'h0);
    endtask

    task automatic t_gate();
        all_banks_idle = 1'b0;
        req_valid = 1'b1; req_sel = 1'b1; req_hts = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R5 banks busy nop", 32'(pins()), 32'h7);
            chk("R5 banks busy no busy", 32'(busy), 32'h0);
        end
        all_banks_idle = 1'b1; cke_high = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R5 cke low nop", 32'(pins()), 32'h7);
        end
        cke_high = 1'b1;
        do_write(1'b1, 1'b0, 2'b11, '0, "R5 released");
    endtask

    task automatic t_reg2();
        do_write(1'b0, 1'b0, 2'b10, '0, "R3 reg2 off");
        chk("R8 init after reg2", 32'(init_done), 32'h1);
        do_write(1'b0, 1'b1, 2'b10, ROW_W'(1) << 7, "R3 reg2 on");
        chk("R8 init sticky", 32'(init_done), 32'h1);
    endtask

    task automatic t_busy_hold();
        req_valid = 1'b1; req_sel = 1'b1; req_hts = 1'b1;
        @(negedge clk);
        chk("R7 first write", 32'(pins()), 32'h0);
        req_sel = 1'b0; req_hts = 1'b1;
        for (int k = 1; k < T_MRD; k++) begin
            @(negedge clk);
            chk("R7 held off", 32'(pins()), 32'h7);
        end
        @(negedge clk);
        chk("R7 done cycle", 32'(done), 32'h1);
        chk("R7 nop in done", 32'(pins()), 32'h7);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 held request issued", 32'(pins()), 32'h0);
        chk("R7 held bank", 32'(cmd_ba), 32'h2);
        chk("R7 held row", 32'(cmd_addr), 32'h80);
        repeat (T_MRD + 1) @(negedge clk);
    endtask

    // Pulse one input for a single cycle; returns at the first falling edge after the sampling edge
    task automatic pulse(input int which);
        if (which == 0) dll_reset = 1'b1;
        if (which == 1) sr_enter  = 1'b1;
        if (which == 2) sr_exit   = 1'b1;
        @(negedge clk);
        dll_reset = 1'b0; sr_enter = 1'b0; sr_exit = 1'b0;
    endtask

    task automatic wait_lock(input string tag);
        repeat (LOCK - 1) @(negedge clk);
        chk({tag, " still low"}, 32'(read_ok), 32'h0);
        @(negedge clk);
        chk({tag, " rises"}, 32'(read_ok), 32'h1);
    endtask

    task automatic t_dll();
        repeat (LOCK + 20) @(negedge clk);
        chk("R9 no enable no read", 32'(read_ok), 32'h0);
        pulse(0);
        chk("R9 low after enable", 32'(read_ok), 32'h0);
        wait_lock("R9 lock");
        pulse(0);
        chk("R10 reset drops read", 32'(read_ok), 32'h0);
        repeat (99) @(negedge clk);
        pulse(0);
        wait_lock("R10 restart");
    endtask

    task automatic t_sr();
        pulse(1);
        chk("R11 entry blocks", 32'(read_ok), 32'h0);
        repeat (5) @(negedge clk);
        pulse(0);
        repeat (LOCK + 10) @(negedge clk);
        chk("R11 dll_reset ignored in sr", 32'(read_ok), 32'h0);
        pulse(2);
        chk("R11 low after exit", 32'(read_ok), 32'h0);
        wait_lock("R11 exit");
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_sel = 1'b0; req_hts = 1'b0;
        all_banks_idle = 1'b1; cke_high = 1'b1;
        dll_reset = 1'b0; sr_enter = 1'b0; sr_exit = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        @(negedge clk);
        t_reg3();
        t_gate();
        t_reg2();
        t_busy_hold();
        t_dll();
        t_sr();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule